// File: doc/BRIEF.md
# Successive Cancellation Polar Decoder (length 8)

This block recovers the eight source bits of one polar codeword from eight signed channel log-likelihood ratios. A single start strobe captures the LLR vector and a frozen-position mask. A fixed schedule then walks a binary tree of shared processing elements for 14 cycles. Each cycle has exactly one tree level active. Each active element applies either the min-sum check update (f) or the sign-controlled add update (g).

The intermediate LLRs of a level live in that level's own registers. Values written by f are overwritten by the g results of the same level once both of their readers have consumed them. When the bottom element produces a value, a decision unit turns it into the next source bit and feeds that bit back. A partial-sum unit folds the bit into the XOR sums that later g updates use. Decoded bits appear one at a time in order u0..u7, each with a one-hot valid strobe. A done pulse marks the last bit.

The code length is set by a log2 parameter (default 3) and the LLR width by a second parameter (default 6). All level sizes, register counts and schedule lengths derive from these two parameters.

Top module: `polar_sc_dec`

## Requirements
- R1: After a start is captured at clock edge E0, bit u_i is reported at edge E0+t_i with t = 3,4,6,7,10,11,13,14 for i = 0..7. At that edge bit_vld_o equals 1<<i for one cycle, and bit_vld_o is zero otherwise.
- R2: The f update returns the product of the input signs times the smaller input magnitude. That magnitude is limited to +31 (a -32 input counts as magnitude 32).
- R3: The g update returns b + a when the partial sum is 0 and b - a when it is 1. The result saturates to [-32, +31] instead of wrapping.
- R4: frozen_i[i] = 1 forces u_i to 0. An unfrozen u_i is 0 when its final LLR is strictly positive and 1 when it is zero or negative.
- R5: The g update of each element uses the XOR-encoded sum of the already decided bits of its left sibling subtree. A node's left half is the XOR of the two child encodings and its right half is the right child's encoding.
- R6: bits_o is zero after reset, clears to zero at a captured start, and sets bits_o[i] = u_i as each bit is decided. It holds the full result after the decode ends.
- R7: done_o is high for exactly one cycle, in the same cycle as the u7 strobe.
- R8: A start asserted while a decode is in progress is ignored. It changes neither the captured LLRs, the mask nor the schedule.
- R9: A start asserted in the cycle done_o is high is captured, and the next decode follows R1 from that edge.
- R10: llr_i[j*6 +: 6] is channel LLR j in two's complement, frozen_i[i] belongs to u_i and bits_o[i] is u_i. Both inputs are sampled only at the captured start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, captured only when idle |
| llr_i | input | 48 | Eight packed 6-bit channel LLRs |
| frozen_i | input | 8 | Frozen-position mask, one bit per source bit |
| bits_o | output | 8 | Decoded source bits |
| bit_vld_o | output | 8 | One-hot strobe for the bit decided this cycle |
| done_o | output | 1 | One-cycle pulse with the final bit |

## Verification
The bench targets saturation at both rails. With every LLR at +31, a wrapping g adder turns 62 into a negative value and flips u7 to 1. With every LLR at -32, a f update that passes magnitude 32 through would also corrupt the bits. Zero-valued LLRs check the tie rule, which a design using a non-strict comparison would decode as 0. A start pulse in mid-decode with inverted data checks R8: a design that re-arms would emit extra strobes or mix in the new data. Back-to-back decodes started in the done cycle check R9: a design that clears its busy flag late would drop the second codeword. Mixed-sign and random vectors with a typical frozen mask check the partial-sum feedback, which would give wrong later bits if the XOR encoding or its write level were off.

// File: rtl/polar_sc_pkg.sv
package polar_sc_pkg;

   // Function applied by every active processing element in a cycle.
   typedef enum logic {
      OP_F = 1'b0,
      OP_G = 1'b1
   } pe_op_e;

   // Flat-array offset of tree level lvl (level lvl holds 2**lvl entries).
   function automatic int tree_base(input int lvl);
      return (1 << lvl) - 1;
   endfunction

endpackage

// File: rtl/polar_sc_pe.sv
module polar_sc_pe
   import polar_sc_pkg::*;
#(
   parameter int LLR_W = 6
) (
   input  logic signed [LLR_W-1:0] a_i,
   input  logic signed [LLR_W-1:0] b_i,
   input  logic                    psum_i,
   input  pe_op_e                  op_i,
   output logic signed [LLR_W-1:0] y_o
);

   localparam int EXT_W = LLR_W + 2;
   localparam int MAXV  = (1 << (LLR_W - 1)) - 1;
   localparam int MINV  = -(1 << (LLR_W - 1));

   logic signed [EXT_W-1:0] a_ext, b_ext, mag_a, mag_b, mag_min, f_val, g_sum, g_sat;

   always_comb begin
      a_ext   = EXT_W'(a_i);
      b_ext   = EXT_W'(b_i);
      mag_a   = (a_ext < 0) ? -a_ext : a_ext;
      mag_b   = (b_ext < 0) ? -b_ext : b_ext;
      mag_min = (mag_a < mag_b) ? mag_a : mag_b;
      if (mag_min > MAXV) mag_min = EXT_W'(MAXV);
      f_val   = (a_i[LLR_W-1] ^ b_i[LLR_W-1]) ? -mag_min : mag_min;
      g_sum   = psum_i ? (b_ext - a_ext) : (b_ext + a_ext);
      if (g_sum > MAXV)      g_sat = EXT_W'(MAXV);
      else if (g_sum < MINV) g_sat = EXT_W'(MINV);
      else                   g_sat = g_sum;
      y_o = (op_i == OP_G) ? g_sat[LLR_W-1:0] : f_val[LLR_W-1:0];
   end

endmodule

// File: rtl/polar_sc_ctrl.sv
module polar_sc_ctrl
   import polar_sc_pkg::*;
#(
   parameter  int LOG_N = 3,
   localparam int N     = 1 << LOG_N,
   localparam int SW    = $clog2(LOG_N + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             busy_o,
   output logic [SW-1:0]    stage_o,
   output pe_op_e           op_o,
   output logic [LOG_N-1:0] idx_o,
   output logic             dec_o
);

   logic             busy_q;
   logic [SW-1:0]    stage_q;
   pe_op_e           op_q;
   logic [LOG_N-1:0] idx_q, idx_nxt;

   // Highest level touched by the next bit: its lowest set index bit.
   function automatic logic [SW-1:0] low_one(input logic [LOG_N-1:0] v);
      logic [SW-1:0] r;
      r = '0;
      for (int k = LOG_N - 1; k >= 0; k--) begin
         if (v[k]) r = SW'(k);
      end
      return r;
   endfunction

   assign idx_nxt = idx_q + 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q  <= 1'b0;
         stage_q <= '0;
         op_q    <= OP_F;
         idx_q   <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q  <= 1'b1;
            stage_q <= SW'(LOG_N - 1);
            op_q    <= OP_F;
            idx_q   <= '0;
         end
      end else if (stage_q == '0) begin
         if (idx_q == LOG_N'(N - 1)) begin
            busy_q <= 1'b0;
         end else begin
            idx_q   <= idx_nxt;
            stage_q <= low_one(idx_nxt);
            op_q    <= OP_G;
         end
      end else begin
         stage_q <= stage_q - 1'b1;
         op_q    <= OP_F;
      end
   end

   assign busy_o  = busy_q;
   assign stage_o = stage_q;
   assign op_o    = op_q;
   assign idx_o   = idx_q;
   assign dec_o   = busy_q && (stage_q == '0);

   // R1: a non-bottom level is always followed by the level below, using f
   p_stage_walk_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q && stage_q != '0 |=> busy_q && stage_q == $past(stage_q) - 1'b1 && op_q == OP_F);

   // R5: after a decided bit that is not the last, the next bit opens with g
   p_next_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q && stage_q == '0 && idx_q != LOG_N'(N - 1)
      |=> busy_q && op_q == OP_G && idx_q == $past(idx_q) + 1'b1);

   // R7: the decode ends right after the last bit
   p_finish_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q && stage_q == '0 && idx_q == LOG_N'(N - 1) |=> !busy_q);

   // R8: a start in mid-decode does not restart the schedule
   p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q && start_i && stage_q != '0
      |=> busy_q && idx_q == $past(idx_q) && stage_q != SW'(LOG_N - 1));

endmodule

// File: rtl/polar_sc_psum.sv
module polar_sc_psum
   import polar_sc_pkg::*;
#(
   parameter  int LOG_N = 3,
   localparam int N     = 1 << LOG_N,
   localparam int SW    = $clog2(LOG_N + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [LOG_N-1:0] idx_i,
   input  logic             bit_i,
   output logic [N-2:0]     psum_o
);

   logic [N-2:0]  ps_q;
   logic [N-2:0]  chain;
   logic [SW-1:0] wlev;

   // chain holds, per level k, the encoding of the subtree just completed
   // at level k when bit_i closes it.
   assign chain[0] = bit_i;
   for (genvar k = 1; k < LOG_N; k++) begin : g_lvl
      for (genvar j = 0; j < (1 << k); j++) begin : g_ent
         if (j < (1 << (k - 1))) begin : g_left
            assign chain[tree_base(k) + j] = ps_q[tree_base(k - 1) + j] ^ chain[tree_base(k - 1) + j];
         end else begin : g_right
            assign chain[tree_base(k) + j] = chain[tree_base(k - 1) + j - (1 << (k - 1))];
         end
      end
   end

   // The completed subtree is a left child at the lowest zero bit of idx.
   always_comb begin
      wlev = '0;
      for (int k = LOG_N - 1; k >= 0; k--) begin
         if (!idx_i[k]) wlev = SW'(k);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ps_q <= '0;
      end else if (we_i && idx_i != LOG_N'(N - 1)) begin
         for (int k = 0; k < LOG_N; k++) begin
            if (wlev == SW'(k)) begin
               for (int j = 0; j < (1 << k); j++) begin
                  ps_q[tree_base(k) + j] <= chain[tree_base(k) + j];
               end
            end
         end
      end
   end

   assign psum_o = ps_q;

endmodule

// File: rtl/polar_sc_dec.sv
module polar_sc_dec
   import polar_sc_pkg::*;
#(
   parameter  int LOG_N = 3,
   parameter  int LLR_W = 6,
   localparam int N     = 1 << LOG_N
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [N*LLR_W-1:0] llr_i,
   input  logic [N-1:0]       frozen_i,
   output logic [N-1:0]       bits_o,
   output logic [N-1:0]       bit_vld_o,
   output logic               done_o
);

   localparam int SW     = $clog2(LOG_N + 1);
   localparam int NODE_HI = 2 * N - 2;

   if (LOG_N < 1 || LOG_N > 8) begin : g_bad_log_n
      $error("LOG_N must lie in 1..8");
   end
   if (LLR_W < 3) begin : g_bad_llr_w
      $error("LLR_W must be at least 3");
   end

   logic             busy, dec;
   logic [SW-1:0]    stage;
   pe_op_e           op;
   logic [LOG_N-1:0] idx;
   logic [N-2:0]     psum;
   logic             accept, dbit;
   logic [N-1:0]     frz_q, bits_q, vld_q;
   logic             done_q;

   // Node storage levels 1..LOG_N-1 plus channel level LOG_N, flat-indexed.
   logic signed [LLR_W-1:0] node_q [1:NODE_HI];
   logic signed [LLR_W-1:0] pe_y   [0:N-2];

   assign accept = start_i && !busy;

   polar_sc_ctrl #(.LOG_N(LOG_N)) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .busy_o  (busy),
      .stage_o (stage),
      .op_o    (op),
      .idx_o   (idx),
      .dec_o   (dec)
   );

   polar_sc_psum #(.LOG_N(LOG_N)) u_psum (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (dec),
      .idx_i  (idx),
      .bit_i  (dbit),
      .psum_o (psum)
   );

   // Tree of PEs: level l has 2**l elements reading level l+1.
   for (genvar l = 0; l < LOG_N; l++) begin : g_stage
      for (genvar j = 0; j < (1 << l); j++) begin : g_pe
         polar_sc_pe #(.LLR_W(LLR_W)) u_pe (
            .a_i    (node_q[tree_base(l + 1) + j]),
            .b_i    (node_q[tree_base(l + 1) + j + (1 << l)]),
            .psum_i (psum[tree_base(l) + j]),
            .op_i   (op),
            .y_o    (pe_y[tree_base(l) + j])
         );
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int e = 1; e <= NODE_HI; e++) node_q[e] <= '0;
      end else begin
         if (accept) begin
            for (int j = 0; j < N; j++) begin
               node_q[tree_base(LOG_N) + j] <= $signed(llr_i[j*LLR_W +: LLR_W]);
            end
         end
         for (int l = 1; l < LOG_N; l++) begin
            if (busy && stage == SW'(l)) begin
               for (int j = 0; j < (1 << l); j++) begin
                  node_q[tree_base(l) + j] <= pe_y[tree_base(l) + j];
               end
            end
         end
      end
   end

   // Decision unit: frozen forces 0, strictly positive LLR gives 0.
   assign dbit = !frz_q[idx] && !(pe_y[0] > 0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         frz_q  <= '0;
         bits_q <= '0;
         vld_q  <= '0;
         done_q <= 1'b0;
      end else begin
         vld_q  <= '0;
         done_q <= 1'b0;
         if (accept) begin
            frz_q  <= frozen_i;
            bits_q <= '0;
         end
         if (dec) begin
            bits_q[idx] <= dbit;
            vld_q       <= N'(1) << idx;
            done_q      <= (idx == LOG_N'(N - 1));
         end
      end
   end

   assign bits_o    = bits_q;
   assign bit_vld_o = vld_q;
   assign done_o    = done_q;

   // R1: at most one bit is reported per cycle
   p_vld_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(bit_vld_o));

   // R1: bits are reported in ascending order with no gap inside a pair
   p_vld_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|bit_vld_o) && !bit_vld_o[N-1]
      |=> !(|bit_vld_o) || bit_vld_o == ($past(bit_vld_o) << 1));

   // R7: done accompanies the last bit
   p_done_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> bit_vld_o[N-1]);

   // R4: a reported frozen position is zero
   p_frozen_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(bit_vld_o & frz_q)) |-> !(|(bit_vld_o & bits_o)));

endmodule

// File: tb/sim_polar_sc_dec.sv
module sim_polar_sc_dec;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 8;
   localparam int W  = 6;
   localparam int MAXV = 31;
   localparam int MINV = -32;

   typedef struct {
      int idx;
      int val;
      int cyc;
      bit last;
      logic [N-1:0] vec;
      string tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [N*W-1:0] llr = '0;
   logic [N-1:0] frz = '0;
   logic [N-1:0] bits, vld;
   logic done;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 1'b0;
   item_t exp_q[$];
   logic [N-1:0] last_vec = '0;
   int lat[N] = '{3, 4, 6, 7, 10, 11, 13, 14};

   polar_sc_dec u0 (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .start_i   (start),
      .llr_i     (llr),
      .frozen_i  (frz),
      .bits_o    (bits),
      .bit_vld_o (vld),
      .done_o    (done)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int clampv(input int v);
      if (v > MAXV) return MAXV;
      if (v < MINV) return MINV;
      return v;
   endfunction

   function automatic int f_ref(input int a, input int b);
      int ma, mb, m;
      ma = (a < 0) ? -a : a;
      mb = (b < 0) ? -b : b;
      m  = (ma < mb) ? ma : mb;
      if (m > MAXV) m = MAXV;
      return ((a < 0) != (b < 0)) ? -m : m;
   endfunction

   // Reference SC decode: each bit's LLR is rebuilt from the channel values,
   // with left-sibling bits re-encoded by the polar butterfly.
   function automatic logic [N-1:0] sc_ref(input int ch[N], input logic [N-1:0] fz);
      logic [N-1:0] u;
      int cur[N];
      int nxt[N];
      int enc[N];
      u = '0;
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) cur[j] = ch[j];
         for (int k = 2; k >= 0; k--) begin
            int h;
            h = 1 << k;
            if (((i >> k) & 1) == 0) begin
               for (int j = 0; j < h; j++) nxt[j] = f_ref(cur[j], cur[j + h]);
            end else begin
               int base;
               base = (i >> (k + 1)) << (k + 1);
               for (int j = 0; j < h; j++) enc[j] = int'(u[base + j]);
               for (int s = 1; s < h; s = s * 2) begin
                  for (int j = 0; j < h; j++) begin
                     if ((j & s) == 0) enc[j] = enc[j] ^ enc[j + s];
                  end
               end
               for (int j = 0; j < h; j++)
                  nxt[j] = clampv(cur[j + h] + ((enc[j] != 0) ? -cur[j] : cur[j]));
            end
            for (int j = 0; j < h; j++) cur[j] = nxt[j];
         end
         u[i] = fz[i] ? 1'b0 : ((cur[0] > 0) ? 1'b0 : 1'b1);
      end
      return u;
   endfunction

   function automatic logic [N*W-1:0] pack(input int a[N]);
      logic [N*W-1:0] v;
      for (int j = 0; j < N; j++) v[j*W +: W] = W'(a[j]);
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Driver: called at a falling edge; pushes expected bits and drives one decode.
   task automatic run_case(input int a[N], input logic [N-1:0] fz, input string tag, input bit poke);
      logic [N-1:0] ev;
      int t0;
      ev = sc_ref(a, fz);
      t0 = cyc;
      for (int i = 0; i < N; i++) begin
         item_t it;
         it.idx = i; it.val = int'(ev[i]); it.cyc = t0 + 1 + lat[i];
         it.last = (i == N - 1); it.vec = ev; it.tag = tag;
         exp_q.push_back(it);
      end
      llr = pack(a);
      frz = fz;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      llr = ~llr;       // R10: inputs only sampled at the start edge
      frz = ~fz;
      check(bits == '0, "R6 clear at start", int'(bits), 0);
      for (int k = 0; k < 14; k++) begin
         if (poke && k == 3) begin
            start = 1'b1;  // R8: start while busy must be ignored
            llr = pack(a) ^ {N*W{1'b1}};
         end
         if (poke && k == 4) start = 1'b0;
         @(negedge clk);
      end
      last_vec = ev;
   endtask

   // Monitor: pops and compares as strobes appear.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (|vld) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected strobe", int'(vld), 0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               check(vld == (N'(1) << it.idx), {"R1 strobe ", it.tag}, int'(vld), 1 << it.idx);
               check(cyc == it.cyc, {"R1 timing ", it.tag}, cyc, it.cyc);
               check(int'(bits[it.idx]) == it.val, {"R4/R5 bit ", it.tag}, int'(bits[it.idx]), it.val);
               check(done == it.last, {"R7 done ", it.tag}, int'(done), int'(it.last));
               if (it.last) check(bits == it.vec, {"R6 vector ", it.tag}, int'(bits), int'(it.vec));
            end
         end else if (done) begin
            check(1'b0, "R7 done without last bit", 1, 0);
         end
      end
   end

   initial begin
      int a[N];
      repeat (3) @(negedge clk);
      check(bits == '0 && vld == '0 && done == 1'b0, "R6 reset state", int'({bits, vld, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int j = 0; j < N; j++) a[j] = 7;
      run_case(a, 8'h00, "R4 all positive", 1'b0);
      for (int j = 0; j < N; j++) a[j] = -7;
      run_case(a, 8'h00, "R4 all negative", 1'b0);
      for (int j = 0; j < N; j++) a[j] = 0;
      run_case(a, 8'h00, "R4 zero tie", 1'b0);
      for (int j = 0; j < N; j++) a[j] = -9;
      run_case(a, 8'hFF, "R4 all frozen", 1'b0);
      for (int j = 0; j < N; j++) a[j] = 31;
      run_case(a, 8'h00, "R3 g saturation", 1'b0);
      for (int j = 0; j < N; j++) a[j] = -32;
      run_case(a, 8'h00, "R2 f magnitude limit", 1'b0);
      a = '{5, -3, 12, -20, 7, -1, 2, -9};
      run_case(a, 8'b0001_0111, "R5 mixed", 1'b0);
      a = '{-4, 6, -11, 3, 9, -2, -7, 1};
      run_case(a, 8'b0000_0011, "R8 busy start", 1'b1);
      for (int r = 0; r < 6; r++) begin
         for (int j = 0; j < N; j++) a[j] = int'($urandom_range(0, 63)) - 32;
         run_case(a, (r % 2 == 0) ? 8'b0001_0111 : 8'b0000_0001, "R9 back-to-back random", 1'b0);
      end

      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R1 missing strobes", exp_q.size(), 0);
      check(bits == last_vec, "R6 hold after done", int'(bits), int'(last_vec));
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 20000, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule